// File: doc/BRIEF.md
# Internal Data Space Decoder for an 8-bit Accumulator Core

This block is the on-chip data space of a small 8-bit accumulator controller. It holds 128 bytes of scratch RAM, the stack pointer and the two register-bank select bits of the status word. Every other special register lives outside the block and is reached through a plain single-cycle register port. The core issues one request per cycle. A request can be a byte read or write by direct address, by register number, or indirectly through R0/R1. It can also be a single-bit read, set, clear or complement by bit address, or a push or pop.

The request side is a valid-only stream with no back-pressure. A request is taken in every cycle in which `req_valid` is high. The response appears one cycle later with `rsp_valid` high, and it cannot be stalled. The register port is combinational within the request cycle: `sfr_rdata` must answer `sfr_addr` in that same cycle, and a strobed write lands at the next clock edge.

Top module: `idata_space`

## Requirements
- R1: After reset the stack pointer reads 07h, the bank-select bits are 00, and `rsp_valid` is low.
- R2: `req_op` 0 (direct read) and 1 (direct write) at addresses 00h-7Fh access RAM. A read returns the byte on `rsp_data` one cycle after the request. Write operations return 00h.
- R3: Direct accesses at 80h-FFh other than 81h and D0h go to the register port, with `sfr_rd_en` for reads and `sfr_wr_en`/`sfr_wdata` for writes, in the request cycle. Address 81h is the local stack pointer and never appears on the port.
- R4: Direct address D0h is the status word. Writes go to the port and also load the local bank bits from data bits 4:3. Reads return `sfr_rdata` with bits 4:3 replaced by the local bank bits.
- R5: `req_op` 2/3 read/write register Rn, where n is `req_addr[2:0]`, at RAM byte bank*8+n.
- R6: `req_op` 4/5 read/write indirectly through R0 (when `req_addr[0]`=0) or R1 (when it is 1) of the current bank. A pointer above 7Fh reads 00h, drops the write and raises no port strobe.
- R7: Bit addresses 00h-7Fh select bit (addr&7) of RAM byte 20h+(addr>>3), so bit 7Fh is bit 7 of byte 2Fh.
- R8: Bit addresses 80h-FFh select bit (addr&7) of register (addr&F8h) on the port. A modifying bit op reads and writes that register in the same cycle. Bit ops on D0h also update the bank bits.
- R9: `req_op` 6 reads, 7 sets, 8 clears and 9 complements the bit. All four return the bit's prior value on `rsp_bit` and the prior byte on `rsp_data`, and no other bit of the byte changes.
- R10: `req_op` 10 (push) increments the stack pointer and then writes `req_wdata` at the new value. `req_op` 11 (pop) returns the byte at the stack pointer and then decrements it. Stack addresses above 7Fh behave as in R6.
- R11: `req_op` 12-15 and idle cycles touch no state and respond with 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code (see requirements) |
| req_addr | input | 8 | Direct, register, pointer-select or bit address |
| req_wdata | input | 8 | Write or push data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_data | output | 8 | Read byte, or 00h |
| rsp_bit | output | 1 | Prior bit value for bit operations |
| sfr_rd_en | output | 1 | Register port read strobe |
| sfr_wr_en | output | 1 | Register port write strobe |
| sfr_addr | output | 8 | Register port address |
| sfr_wdata | output | 8 | Register port write data |
| sfr_rdata | input | 8 | Register port read data, same cycle |

## Verification
A stale bank-select value does not show up by itself. It shows up at the next register or indirect access, which lands on the wrong RAM byte and returns a wrong value one cycle later. A wrong stack pointer is seen at the next pop or direct read of 81h. A bad bit-address mapping either corrupts a neighbouring byte, which is seen when that byte is next read, or produces a misaddressed port strobe, which is seen in the request cycle itself. Port strobes are therefore compared in the request cycle and responses in the cycle after it.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [3:0] {
    OP_RD_DIR  = 4'd0,
    OP_WR_DIR  = 4'd1,
    OP_RD_REG  = 4'd2,
    OP_WR_REG  = 4'd3,
    OP_RD_IND  = 4'd4,
    OP_WR_IND  = 4'd5,
    OP_BIT_RD  = 4'd6,
    OP_BIT_SET = 4'd7,
    OP_BIT_CLR = 4'd8,
    OP_BIT_CPL = 4'd9,
    OP_PUSH    = 4'd10,
    OP_POP     = 4'd11,
    OP_NOP12   = 4'd12,
    OP_NOP13   = 4'd13,
    OP_NOP14   = 4'd14,
    OP_NOP15   = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    TG_NONE = 3'd0,
    TG_RAM  = 3'd1,
    TG_SFR  = 3'd2,
    TG_SP   = 3'd3,
    TG_PSW  = 3'd4
  } tgt_e;

  localparam logic [7:0] SP_ADDR   = 8'h81;
  localparam logic [7:0] PSW_ADDR  = 8'hD0;
  localparam logic [7:0] BIT_BASE  = 8'h20;
  localparam logic [7:0] SP_RESET  = 8'h07;

  function automatic logic is_bit_op(op_e op);
    return op inside {OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR, OP_BIT_CPL};
  endfunction
endpackage

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
(
  input  op_e        op,
  input  logic [7:0] addr,
  input  logic [1:0] bank,
  input  logic [7:0] sp,
  input  logic [7:0] ptr,
  output tgt_e       tgt,
  output logic [7:0] byte_addr
);
  // direct window: RAM below 80h, locals at 81h/D0h, port elsewhere
  function automatic tgt_e dir_tgt(logic [7:0] a);
    if (!a[7])             return TG_RAM;
    else if (a == SP_ADDR) return TG_SP;
    else if (a == PSW_ADDR) return TG_PSW;
    else                   return TG_SFR;
  endfunction

  // indirect window: RAM only
  function automatic tgt_e ind_tgt(logic [7:0] a);
    return a[7] ? TG_NONE : TG_RAM;
  endfunction

  always_comb begin
    tgt       = TG_NONE;
    byte_addr = 8'h00;
    unique case (op)
      OP_RD_DIR, OP_WR_DIR: begin
        byte_addr = addr;
        tgt       = dir_tgt(addr);
      end
      OP_RD_REG, OP_WR_REG: begin
        byte_addr = {3'b000, bank, addr[2:0]};
        tgt       = TG_RAM;
      end
      OP_RD_IND, OP_WR_IND: begin
        byte_addr = ptr;
        tgt       = ind_tgt(ptr);
      end
      OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR, OP_BIT_CPL: begin
        if (!addr[7]) begin
          byte_addr = BIT_BASE + {4'h0, addr[6:3]};
          tgt       = TG_RAM;
        end else begin
          byte_addr = {addr[7:3], 3'b000};
          tgt       = (byte_addr == PSW_ADDR) ? TG_PSW : TG_SFR;
        end
      end
      OP_PUSH: begin
        byte_addr = sp + 8'd1;
        tgt       = ind_tgt(byte_addr);
      end
      OP_POP: begin
        byte_addr = sp;
        tgt       = ind_tgt(sp);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idata_bitop.sv
module idata_bitop
  import idata_pkg::*;
(
  input  op_e        op,
  input  logic [7:0] old_byte,
  input  logic [2:0] idx,
  output logic [7:0] new_byte,
  output logic       old_bit
);
  logic [7:0] mask;

  always_comb begin
    mask     = 8'h01 << idx;
    old_bit  = old_byte[idx];
    new_byte = old_byte;
    case (op)
      OP_BIT_SET: new_byte = old_byte | mask;
      OP_BIT_CLR: new_byte = old_byte & ~mask;
      OP_BIT_CPL: new_byte = old_byte ^ mask;
      default:    new_byte = old_byte;
    endcase
  end

  // R9: only the addressed bit may differ
  always_comb begin
    a_r9_other_bits_kept: assert (((new_byte ^ old_byte) & ~mask) == 8'h00);
  end
endmodule

// File: rtl/idata_space.sv
module idata_space
  import idata_pkg::*;
#(
  parameter int RAM_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_op,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_bit,
  output logic       sfr_rd_en,
  output logic       sfr_wr_en,
  output logic [7:0] sfr_addr,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata
);
  localparam int RAW = $clog2(RAM_DEPTH);

  op_e        op;
  tgt_e       tgt;
  logic [7:0] sp_q;
  logic [1:0] bank_q;
  logic [7:0] ptr, byte_addr, ram_rdata, old_byte, new_byte, wval;
  logic       old_bit, is_bit, is_bitmod, is_bytewr, is_rd, do_wr, to_port;
  logic [RAW-1:0] ptr_idx;

  assign op      = op_e'(req_op);
  assign ptr_idx = RAW'({bank_q, 2'b00, req_addr[0]});

  idata_decode u_decode (
    .op(op), .addr(req_addr), .bank(bank_q), .sp(sp_q), .ptr(ptr),
    .tgt(tgt), .byte_addr(byte_addr)
  );

  idata_ram #(.DEPTH(RAM_DEPTH), .DW(8)) u_ram (
    .clk(clk),
    .we(do_wr && tgt == TG_RAM),
    .waddr(byte_addr[RAW-1:0]), .wdata(wval),
    .raddr_a(ptr_idx), .rdata_a(ptr),
    .raddr_b(byte_addr[RAW-1:0]), .rdata_b(ram_rdata)
  );

  idata_bitop u_bitop (
    .op(op), .old_byte(old_byte), .idx(req_addr[2:0]),
    .new_byte(new_byte), .old_bit(old_bit)
  );

  always_comb begin
    unique case (tgt)
      TG_RAM:  old_byte = ram_rdata;
      TG_SFR:  old_byte = sfr_rdata;
      TG_SP:   old_byte = sp_q;
      TG_PSW:  old_byte = {sfr_rdata[7:5], bank_q, sfr_rdata[2:0]};
      default: old_byte = 8'h00;
    endcase
  end

  assign is_bit    = is_bit_op(op);
  assign is_bitmod = op inside {OP_BIT_SET, OP_BIT_CLR, OP_BIT_CPL};
  assign is_bytewr = op inside {OP_WR_DIR, OP_WR_REG, OP_WR_IND, OP_PUSH};
  assign is_rd     = op inside {OP_RD_DIR, OP_RD_REG, OP_RD_IND, OP_POP} || is_bit;
  assign wval      = is_bitmod ? new_byte : req_wdata;
  assign do_wr     = req_valid && (is_bitmod || is_bytewr);
  assign to_port   = (tgt == TG_SFR) || (tgt == TG_PSW);

  assign sfr_addr  = byte_addr;
  assign sfr_wdata = wval;
  assign sfr_wr_en = do_wr && to_port;
  assign sfr_rd_en = req_valid && to_port && (op == OP_RD_DIR || is_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q      <= SP_RESET;
      bank_q    <= 2'b00;
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
      rsp_bit   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_data  <= (req_valid && is_rd) ? old_byte : 8'h00;
      rsp_bit   <= req_valid && is_bit && old_bit;
      if (do_wr && tgt == TG_PSW) bank_q <= wval[4:3];
      if (req_valid && op == OP_PUSH)     sp_q <= sp_q + 8'd1;
      else if (req_valid && op == OP_POP) sp_q <= sp_q - 8'd1;
      else if (do_wr && tgt == TG_SP)     sp_q <= wval;
    end
  end

  // R1: reset state of the local registers
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sp_q == SP_RESET && bank_q == 2'b00));
  // R10: push pre-increments, pop post-decrements
  a_r10_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_PUSH) |=> (sp_q == $past(sp_q) + 8'd1));
  a_r10_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_POP) |=> (sp_q == $past(sp_q) - 8'd1));
  // R6: indirect accesses never reach the port
  a_r6_ind_no_port: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (op == OP_RD_IND || op == OP_WR_IND)) |-> (!sfr_rd_en && !sfr_wr_en));
  // R8: bit traffic on the port is byte aligned to multiples of 8
  a_r8_bit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bit && (sfr_rd_en || sfr_wr_en)) |-> (sfr_addr[2:0] == 3'b000));
  // R3: port sees only the upper window, never the stack pointer
  a_r3_port_window: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd_en || sfr_wr_en) |-> (sfr_addr[7] && sfr_addr != SP_ADDR));
  // R11: response flag tracks the request one cycle later
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/idata_space_tb.sv
`timescale 1ns/1ps
module idata_space_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic [7:0] req_addr = 8'd0, req_wdata = 8'd0;
  logic rsp_valid, rsp_bit, sfr_rd_en, sfr_wr_en;
  logic [7:0] rsp_data, sfr_addr, sfr_wdata, sfr_rdata;

  logic [7:0] sfr_mem [128];
  logic [7:0] m_ram [128];
  logic [7:0] m_sp;
  logic [1:0] m_bank;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  idata_space u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_bit(rsp_bit), .sfr_rd_en(sfr_rd_en),
    .sfr_wr_en(sfr_wr_en), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata)
  );

  assign sfr_rdata = sfr_mem[sfr_addr[6:0]];
  always @(posedge clk) if (sfr_wr_en) sfr_mem[sfr_addr[6:0]] <= sfr_wdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kinds: 0 none, 1 RAM, 2 port, 3 stack pointer, 4 status word
  function automatic int dir_kind(logic [7:0] a);
    if (a < 8'h80) return 1;
    if (a == 8'h81) return 3;
    if (a == 8'hD0) return 4;
    return 2;
  endfunction

  function automatic logic [7:0] model_rd(int k, logic [7:0] a);
    case (k)
      1: return m_ram[a[6:0]];
      2: return sfr_mem[a[6:0]];
      3: return m_sp;
      4: return {sfr_mem[7'h50][7:5], m_bank, sfr_mem[7'h50][2:0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] op, logic [7:0] a);
    case (op)
      4'd0, 4'd1: return (a < 8'h80) ? "R2" : (a == 8'hD0) ? "R4" : "R3";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6, 4'd7, 4'd8, 4'd9: return (a < 8'h80) ? "R7/R9" : "R8/R9";
      4'd10, 4'd11: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run_op(logic [3:0] op, logic [7:0] a, logic [7:0] wd, string tag);
    int k; logic [7:0] ba, old, wv, ed; logic eb, erd, ewr, isbit, iswr;
    @(negedge clk);
    k = 0; ba = 8'h00;
    isbit = (op >= 4'd6 && op <= 4'd9);
    case (op)
      4'd0, 4'd1: begin ba = a; k = dir_kind(a); end
      4'd2, 4'd3: begin ba = {3'b000, m_bank, a[2:0]}; k = 1; end
      4'd4, 4'd5: begin ba = m_ram[{2'b00, m_bank, 2'b00, a[0]}]; k = (ba < 8'h80) ? 1 : 0; end
      4'd6, 4'd7, 4'd8, 4'd9:
        if (a < 8'h80) begin ba = 8'h20 + (a >> 3); k = 1; end
        else begin ba = a & 8'hF8; k = (ba == 8'hD0) ? 4 : 2; end
      4'd10: begin ba = m_sp + 8'd1; k = (ba < 8'h80) ? 1 : 0; end
      4'd11: begin ba = m_sp; k = (ba < 8'h80) ? 1 : 0; end
      default: k = 0;
    endcase
    old = model_rd(k, ba);
    wv = wd;
    if (op == 4'd7) wv = old | (8'h01 << a[2:0]);
    else if (op == 4'd8) wv = old & ~(8'h01 << a[2:0]);
    else if (op == 4'd9) wv = old ^ (8'h01 << a[2:0]);
    iswr = (op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd10 || (op >= 4'd7 && op <= 4'd9));
    ed = (op == 4'd0 || op == 4'd2 || op == 4'd4 || op == 4'd11 || isbit) ? old : 8'h00;
    eb = isbit ? old[a[2:0]] : 1'b0;
    erd = (k == 2 || k == 4) && (op == 4'd0 || isbit);
    ewr = (k == 2 || k == 4) && iswr;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    #1;
    chk({tag, " port strobes"}, {sfr_rd_en, sfr_wr_en}, {erd, ewr});
    if (erd || ewr) chk({tag, " port addr"}, sfr_addr, ba);
    if (ewr) chk({tag, " port wdata"}, sfr_wdata, wv);
    if (iswr) begin
      if (k == 1) m_ram[ba[6:0]] = wv;
      if (k == 3) m_sp = wv;
      if (k == 4) m_bank = wv[4:3];
    end
    if (op == 4'd10) m_sp = m_sp + 8'd1;
    if (op == 4'd11) m_sp = m_sp - 8'd1;
    @(posedge clk); #1;
    chk({tag, " rsp_valid"}, rsp_valid, 1'b1);
    chk({tag, " rsp_data"}, rsp_data, ed);
    chk({tag, " rsp_bit"}, rsp_bit, eb);
    req_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0611));
    for (int i = 0; i < 128; i++) sfr_mem[i] = 8'($urandom);
    m_sp = 8'h07; m_bank = 2'b00;
    repeat (3) @(posedge clk);
    #1 chk("R1 rsp_valid in reset", rsp_valid, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset values seen through direct reads
    run_op(4'd0, 8'h81, 8'h00, "R1 sp");
    run_op(4'd0, 8'hD0, 8'h00, "R1 bank");
    for (int i = 0; i < 128; i++) run_op(4'd1, 8'(i), 8'($urandom), "R2 init");
    // R7: top RAM bit maps to byte 2Fh bit 7
    run_op(4'd1, 8'h2F, 8'h00, "R7");
    run_op(4'd7, 8'h7F, 8'h00, "R7");
    run_op(4'd0, 8'h2F, 8'h00, "R7 byte2F");
    run_op(4'd9, 8'h00, 8'h00, "R9 cpl");
    run_op(4'd6, 8'h00, 8'h00, "R9 read");
    // R4/R8: bit set on status word bit 4 selects bank 2
    run_op(4'd8, 8'hD3, 8'h00, "R8 psw clr");
    run_op(4'd7, 8'hD4, 8'h00, "R8 psw set");
    run_op(4'd3, 8'h05, 8'hA5, "R5 bank2");
    run_op(4'd0, 8'h15, 8'h00, "R5 alias 15h");
    run_op(4'd1, 8'hD0, 8'h18, "R4 bank3");
    run_op(4'd2, 8'h07, 8'h00, "R5 bank3 R7");
    // R6: pointer above 7Fh
    run_op(4'd3, 8'h01, 8'h90, "R6 set R1");
    run_op(4'd5, 8'h01, 8'h3C, "R6 ignored wr");
    run_op(4'd4, 8'h01, 8'h00, "R6 reads zero");
    run_op(4'd3, 8'h00, 8'h40, "R6 set R0");
    run_op(4'd5, 8'h00, 8'h77, "R6 wr");
    run_op(4'd0, 8'h40, 8'h00, "R6 check");
    // R10: stack crossing 7Fh
    run_op(4'd1, 8'h81, 8'h7E, "R3 sp write");
    run_op(4'd10, 8'h00, 8'h11, "R10 push");
    run_op(4'd10, 8'h00, 8'h22, "R10 push high");
    run_op(4'd11, 8'h00, 8'h00, "R10 pop high");
    run_op(4'd11, 8'h00, 8'h00, "R10 pop");
    run_op(4'd0, 8'h81, 8'h00, "R10 sp");
    run_op(4'd12, 8'h10, 8'hFF, "R11 nop");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op; logic [7:0] a;
      op = 4'($urandom_range(0, 15));
      a = 8'($urandom);
      run_op(op, a, 8'($urandom), tag_of(op, a));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule